// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter and Vectorer

This block collects interrupt requests from many kinds of source and tells the processor which request it may take next, given the priority level the processor is running at. Some sources are plain flags with a fixed vector. Some are tracked separately for each CPU, and those count only for the CPU named on `cpu_id`. Four hardware levels each carry a 16-slot request word. At a hardware level the vector is computed from the level and the slot number. The exception is one slot reserved for a bus adapter, whose vector is taken from an input instead. A software request word and a halt pin are sampled directly and are not held.

The arbitration is combinational. Whenever the inputs or the held flags change, `irq_lvl` shows the winning level, or 0 when nothing may be taken. To take an interrupt, the processor raises `ack` for one cycle and puts the level it is taking on `ack_lvl`. On that clock edge the block registers the vector and clears the one request it served. Request set strobes are one-cycle pulses that are captured into internal flags.

Top module: `irq_arbiter`

## Requirements
- R1: While `halt_pin` is high, `irq_lvl` is 0x1F, whatever the value of `cur_ipl`.
- R2: Without halt, the block takes the first eligible source in this order and reports it on `irq_lvl`: corrected-read error (0x1A); clock, current CPU's bit (0x18); hardware levels 0x17 down to 0x14, where any set slot counts; console-data (0x13); inter-processor, current CPU's bit (0x12); floppy (0x11); console (0x10), where receive counts only when `cpu_id` is 0 and transmit uses the current CPU's bit. A source is eligible only when its level is strictly greater than `cur_ipl`. With no eligible source, `irq_lvl` is 0.
- R3: Bit k of `sw_req` requests level k+1. When no other source wins, the highest set bit whose level is strictly greater than `cur_ipl` wins. When `cur_ipl` is 0x0F or above, no software level is taken.
- R4: An acknowledge at a hardware level whose adapter slot (slot 3) is set returns `adp_vec` and clears only that slot bit.
- R5: Otherwise, an acknowledge at a hardware level clears the lowest-numbered set slot and returns 0x100 + (level − 0x14)·0x40 + slot·4.
- R6: An acknowledge at a fixed-source level clears that source and returns its vector: 0x054 for read error, 0x0C0 for clock, 0x0C8 for console-data, 0x0CC for inter-processor, 0x0D0 for floppy, 0x0F8 for receive and 0x0FC for transmit. For clock, inter-processor and transmit, only the current CPU's bit is cleared. At level 0x10, receive (when `cpu_id` is 0) is served before transmit. An acknowledge at a level with nothing pending returns 0.
- R7: `vec_valid` is high for exactly the one cycle that follows an edge where `ack` is high. `vec_out` holds the vector from that edge.
- R8: An acknowledge at a software level 1..0x0F returns 0x080 + level·4 and clears nothing.
- R9: An acknowledge at a level above 0x17 that is neither 0x1A nor 0x18 raises `ack_err` for that one result cycle and returns vector 0.
- R10: When a set strobe arrives on the same edge that an acknowledge clears the same flag, the flag stays set.
- R11: A synchronous reset (`rst_n` low) clears every held flag, `vec_out`, `vec_valid` and `ack_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_pin | input | 1 | Halt request, not held |
| crd_set | input | 1 | Set strobe for the corrected-read error flag |
| clk_set | input | NCPU | Per-CPU clock request set strobes |
| hw_set | input | HW_LEVELS·SLOTS | Slot set strobes, bit level·SLOTS+slot |
| cdat_set | input | 1 | Console-data request set strobe |
| ipi_set | input | NCPU | Per-CPU inter-processor set strobes |
| flp_set | input | 1 | Floppy request set strobe |
| rx_set | input | 1 | Console receive request set strobe |
| tx_set | input | NCPU | Per-CPU console transmit set strobes |
| sw_req | input | 15 | Software request word, bit k is level k+1 |
| cpu_id | input | CPU_W | Index of the current CPU |
| cur_ipl | input | 5 | Current processor priority level |
| adp_vec | input | VEC_W | Vector supplied by the bus adapter |
| ack | input | 1 | One-cycle acknowledge strobe |
| ack_lvl | input | 5 | Level being acknowledged |
| irq_lvl | output | 5 | Winning level, 0 when none |
| vec_out | output | VEC_W | Vector registered on acknowledge |
| vec_valid | output | 1 | High for one cycle after an acknowledge |
| ack_err | output | 1 | Acknowledge at an unserved high level |

## Verification
Two functions can land on the same clock edge: a set strobe for a flag, and the acknowledge that clears that flag. This happens at single flags, at per-CPU bits and at hardware slots. The bench forces it directly with the floppy source, then checks that the floppy level is still reported afterwards. Random stimulus then keeps producing such collisions across all sources. Each collision is judged against a bench model that applies the acknowledge's clear first and the new sets second, and every later `irq_lvl` and vector is compared with that model.

// File: rtl/irq_arb_pkg.sv
// Package irq_arb_pkg
// Shared level codes, fixed vectors and flag indices for the interrupt arbiter.
// Assumes 5-bit priority levels; hardware levels start at LVL_HW_BOT.
package irq_arb_pkg;

    localparam int LVL_W = 5;

    localparam logic [LVL_W-1:0] LVL_NONE   = 5'h00;
    localparam logic [LVL_W-1:0] LVL_HALT   = 5'h1F;
    localparam logic [LVL_W-1:0] LVL_CRD    = 5'h1A;
    localparam logic [LVL_W-1:0] LVL_CLK    = 5'h18;
    localparam logic [LVL_W-1:0] LVL_HW_BOT = 5'h14;
    localparam logic [LVL_W-1:0] LVL_CDAT   = 5'h13;
    localparam logic [LVL_W-1:0] LVL_IPI    = 5'h12;
    localparam logic [LVL_W-1:0] LVL_FLP    = 5'h11;
    localparam logic [LVL_W-1:0] LVL_CON    = 5'h10;
    localparam logic [LVL_W-1:0] LVL_SW_MAX = 5'h0F;

    localparam int SW_BITS = 15;

    localparam int VEC_CRD  = 'h054;
    localparam int VEC_CLK  = 'h0C0;
    localparam int VEC_CDAT = 'h0C8;
    localparam int VEC_IPI  = 'h0CC;
    localparam int VEC_FLP  = 'h0D0;
    localparam int VEC_RX   = 'h0F8;
    localparam int VEC_TX   = 'h0FC;
    localparam int VEC_SW_BASE  = 'h080;
    localparam int VEC_NEX_BASE = 'h100;

    // Index of each single (not per-CPU) held flag
    localparam int FX_CRD  = 0;
    localparam int FX_CDAT = 1;
    localparam int FX_FLP  = 2;
    localparam int FX_RX   = 3;
    localparam int FX_NUM  = 4;

    typedef logic [FX_NUM-1:0] fixed_flags_t;

endpackage

// File: rtl/irq_flag_bank.sv
// Module irq_flag_bank
// Holds every latched interrupt request flag. Each flag is set by its strobe
// and cleared by the matching clear strobe; a set on the same edge wins.
// Assumes set/clear strobes are synchronous one-cycle pulses.
module irq_flag_bank
    import irq_arb_pkg::*;
#(
    parameter int NCPU      = 2,
    parameter int SLOTS     = 16,
    parameter int HW_LEVELS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  fixed_flags_t               fx_set,
    input  fixed_flags_t               fx_clr,
    input  logic [NCPU-1:0]            clk_set,
    input  logic [NCPU-1:0]            clk_clr,
    input  logic [NCPU-1:0]            ipi_set,
    input  logic [NCPU-1:0]            ipi_clr,
    input  logic [NCPU-1:0]            tx_set,
    input  logic [NCPU-1:0]            tx_clr,
    input  logic [HW_LEVELS*SLOTS-1:0] hw_set,
    input  logic [HW_LEVELS*SLOTS-1:0] hw_clr,
    output fixed_flags_t               fx_q,
    output logic [NCPU-1:0]            clk_q,
    output logic [NCPU-1:0]            ipi_q,
    output logic [NCPU-1:0]            tx_q,
    output logic [HW_LEVELS*SLOTS-1:0] hw_q
);

    // Single flags: clear what was served, then merge new requests
    always_ff @(posedge clk) begin
        if (!rst_n) fx_q <= '0;
        else        fx_q <= (fx_q & ~fx_clr) | fx_set;
    end

    // One group of per-CPU flags for each CPU
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        // Per-CPU clock, inter-processor and transmit bits
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_q[c] <= 1'b0;
                ipi_q[c] <= 1'b0;
                tx_q[c]  <= 1'b0;
            end else begin
                clk_q[c] <= (clk_q[c] & ~clk_clr[c]) | clk_set[c];
                ipi_q[c] <= (ipi_q[c] & ~ipi_clr[c]) | ipi_set[c];
                tx_q[c]  <= (tx_q[c]  & ~tx_clr[c])  | tx_set[c];
            end
        end

        AST_CLK_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            clk_set[c] |=> clk_q[c]);  // R10
    end

    // One request word for each hardware level
    for (genvar l = 0; l < HW_LEVELS; l++) begin : g_hw
        localparam int LO = l * SLOTS;

        // Slot word of hardware level l
        always_ff @(posedge clk) begin
            if (!rst_n) hw_q[LO +: SLOTS] <= '0;
            else        hw_q[LO +: SLOTS] <= (hw_q[LO +: SLOTS] & ~hw_clr[LO +: SLOTS])
                                             | hw_set[LO +: SLOTS];
        end

        AST_HW_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hw_clr[LO +: SLOTS]));  // R5

        AST_HW_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_set[LO +: SLOTS] != '0) |=>
            ((hw_q[LO +: SLOTS] & $past(hw_set[LO +: SLOTS])) == $past(hw_set[LO +: SLOTS])));  // R10
    end

    AST_FLP_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fx_set[FX_FLP] |=> fx_q[FX_FLP]);  // R10

endmodule

// File: rtl/irq_prio_sel.sv
// Module irq_prio_sel
// Combinational priority scan: returns the highest level that may be taken
// above the current priority level, or LVL_NONE.
// Assumes cpu_mask is one-hot (or zero) for the current CPU.
module irq_prio_sel
    import irq_arb_pkg::*;
#(
    parameter int NCPU      = 2,
    parameter int SLOTS     = 16,
    parameter int HW_LEVELS = 4
) (
    input  logic                       halt_pin,
    input  fixed_flags_t               fx_q,
    input  logic [NCPU-1:0]            clk_q,
    input  logic [NCPU-1:0]            ipi_q,
    input  logic [NCPU-1:0]            tx_q,
    input  logic [HW_LEVELS*SLOTS-1:0] hw_q,
    input  logic [SW_BITS-1:0]         sw_req,
    input  logic [NCPU-1:0]            cpu_mask,
    input  logic                       cpu_is0,
    input  logic [LVL_W-1:0]           cur_ipl,
    output logic [LVL_W-1:0]           irq_lvl
);

    logic done;

    // Ordered scan from the most to the least urgent source
    always_comb begin
        irq_lvl = LVL_NONE;
        done    = 1'b0;
        if (halt_pin) begin
            irq_lvl = LVL_HALT;
            done    = 1'b1;
        end
        if (!done && fx_q[FX_CRD] && (cur_ipl < LVL_CRD)) begin
            irq_lvl = LVL_CRD;
            done    = 1'b1;
        end
        if (!done && ((clk_q & cpu_mask) != '0) && (cur_ipl < LVL_CLK)) begin
            irq_lvl = LVL_CLK;
            done    = 1'b1;
        end
        for (int l = HW_LEVELS - 1; l >= 0; l--) begin
            if (!done) begin
                if (LVL_W'(int'(LVL_HW_BOT) + l) <= cur_ipl) begin
                    done = 1'b1;
                end else if (hw_q[l*SLOTS +: SLOTS] != '0) begin
                    irq_lvl = LVL_W'(int'(LVL_HW_BOT) + l);
                    done    = 1'b1;
                end
            end
        end
        if (!done && fx_q[FX_CDAT] && (cur_ipl < LVL_CDAT)) begin
            irq_lvl = LVL_CDAT;
            done    = 1'b1;
        end
        if (!done && ((ipi_q & cpu_mask) != '0) && (cur_ipl < LVL_IPI)) begin
            irq_lvl = LVL_IPI;
            done    = 1'b1;
        end
        if (!done && fx_q[FX_FLP] && (cur_ipl < LVL_FLP)) begin
            irq_lvl = LVL_FLP;
            done    = 1'b1;
        end
        if (!done && (cur_ipl < LVL_CON) &&
            ((fx_q[FX_RX] && cpu_is0) || ((tx_q & cpu_mask) != '0))) begin
            irq_lvl = LVL_CON;
            done    = 1'b1;
        end
        if (cur_ipl >= LVL_SW_MAX) done = 1'b1;
        for (int k = SW_BITS - 1; k >= 0; k--) begin
            if (!done && sw_req[k] && (LVL_W'(k + 1) > cur_ipl)) begin
                irq_lvl = LVL_W'(k + 1);
                done    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vec_sel.sv
// Module irq_vec_sel
// Combinational acknowledge decode: for the acknowledged level, picks the
// request to serve, forms its vector and raises one clear strobe.
// Assumes clears are only acted on when ack is high (gated here).
module irq_vec_sel
    import irq_arb_pkg::*;
#(
    parameter int NCPU      = 2,
    parameter int SLOTS     = 16,
    parameter int HW_LEVELS = 4,
    parameter int VEC_W     = 16,
    parameter int ADP_SLOT  = 3
) (
    input  logic                       ack,
    input  logic [LVL_W-1:0]           ack_lvl,
    input  fixed_flags_t               fx_q,
    input  logic [NCPU-1:0]            clk_q,
    input  logic [NCPU-1:0]            ipi_q,
    input  logic [NCPU-1:0]            tx_q,
    input  logic [HW_LEVELS*SLOTS-1:0] hw_q,
    input  logic [NCPU-1:0]            cpu_mask,
    input  logic                       cpu_is0,
    input  logic [VEC_W-1:0]           adp_vec,
    output logic [VEC_W-1:0]           vec,
    output logic                       err,
    output fixed_flags_t               fx_clr,
    output logic [NCPU-1:0]            clk_clr,
    output logic [NCPU-1:0]            ipi_clr,
    output logic [NCPU-1:0]            tx_clr,
    output logic [HW_LEVELS*SLOTS-1:0] hw_clr
);

    localparam int LVL_STRIDE = SLOTS * 4;
    localparam logic [LVL_W-1:0] LVL_HW_TOP = LVL_W'(int'(LVL_HW_BOT) + HW_LEVELS - 1);

    logic [SLOTS-1:0] word;
    int               pick;
    logic             found;

    // Serve one request at the acknowledged level
    always_comb begin
        vec     = '0;
        err     = 1'b0;
        fx_clr  = '0;
        clk_clr = '0;
        ipi_clr = '0;
        tx_clr  = '0;
        hw_clr  = '0;
        word    = '0;
        pick    = 0;
        found   = 1'b0;
        if (ack) begin
            if (ack_lvl == LVL_CRD) begin
                if (fx_q[FX_CRD]) begin
                    fx_clr[FX_CRD] = 1'b1;
                    vec = VEC_W'(VEC_CRD);
                end
            end else if (ack_lvl == LVL_CLK) begin
                if ((clk_q & cpu_mask) != '0) begin
                    clk_clr = cpu_mask;
                    vec = VEC_W'(VEC_CLK);
                end
            end else if (ack_lvl > LVL_HW_TOP) begin
                err = 1'b1;
            end else if (ack_lvl >= LVL_HW_BOT) begin
                for (int l = 0; l < HW_LEVELS; l++) begin
                    if (ack_lvl == LVL_W'(int'(LVL_HW_BOT) + l)) begin
                        word = hw_q[l*SLOTS +: SLOTS];
                        if (word[ADP_SLOT]) begin
                            hw_clr[l*SLOTS + ADP_SLOT] = 1'b1;
                            vec = adp_vec;
                        end else begin
                            for (int s = SLOTS - 1; s >= 0; s--) begin
                                if (word[s]) begin
                                    pick  = s;
                                    found = 1'b1;
                                end
                            end
                            if (found) begin
                                hw_clr[l*SLOTS + pick] = 1'b1;
                                vec = VEC_W'(VEC_NEX_BASE + l * LVL_STRIDE + pick * 4);
                            end
                        end
                    end
                end
            end else if (ack_lvl == LVL_CDAT) begin
                if (fx_q[FX_CDAT]) begin
                    fx_clr[FX_CDAT] = 1'b1;
                    vec = VEC_W'(VEC_CDAT);
                end
            end else if (ack_lvl == LVL_IPI) begin
                if ((ipi_q & cpu_mask) != '0) begin
                    ipi_clr = cpu_mask;
                    vec = VEC_W'(VEC_IPI);
                end
            end else if (ack_lvl == LVL_FLP) begin
                if (fx_q[FX_FLP]) begin
                    fx_clr[FX_FLP] = 1'b1;
                    vec = VEC_W'(VEC_FLP);
                end
            end else if (ack_lvl == LVL_CON) begin
                if (fx_q[FX_RX] && cpu_is0) begin
                    fx_clr[FX_RX] = 1'b1;
                    vec = VEC_W'(VEC_RX);
                end else if ((tx_q & cpu_mask) != '0) begin
                    tx_clr = cpu_mask;
                    vec = VEC_W'(VEC_TX);
                end
            end else if (ack_lvl != LVL_NONE) begin
                vec = VEC_W'(VEC_SW_BASE + 4 * int'(ack_lvl));
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module irq_arbiter (top)
// Prioritized interrupt arbiter and vectorer. Latches request strobes, reports
// the winning level combinationally and, on a one-cycle acknowledge, registers
// the vector and clears the served request on the same edge.
// Assumes synchronous active-low reset and cpu_id below NCPU.
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NCPU      = 2,
    parameter int SLOTS     = 16,
    parameter int HW_LEVELS = 4,
    parameter int VEC_W     = 16,
    parameter int ADP_SLOT  = 3,
    parameter int CPU_W     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       halt_pin,
    input  logic                       crd_set,
    input  logic [NCPU-1:0]            clk_set,
    input  logic [HW_LEVELS*SLOTS-1:0] hw_set,
    input  logic                       cdat_set,
    input  logic [NCPU-1:0]            ipi_set,
    input  logic                       flp_set,
    input  logic                       rx_set,
    input  logic [NCPU-1:0]            tx_set,
    input  logic [14:0]                sw_req,
    input  logic [CPU_W-1:0]           cpu_id,
    input  logic [4:0]                 cur_ipl,
    input  logic [VEC_W-1:0]           adp_vec,
    input  logic                       ack,
    input  logic [4:0]                 ack_lvl,
    output logic [4:0]                 irq_lvl,
    output logic [VEC_W-1:0]           vec_out,
    output logic                       vec_valid,
    output logic                       ack_err
);

    localparam int HW_W = HW_LEVELS * SLOTS;

    fixed_flags_t    fx_set, fx_clr, fx_q;
    logic [NCPU-1:0] clk_clr, ipi_clr, tx_clr;
    logic [NCPU-1:0] clk_q, ipi_q, tx_q;
    logic [HW_W-1:0] hw_clr, hw_q;
    logic [NCPU-1:0] cpu_mask;
    logic            cpu_is0;
    logic [VEC_W-1:0] vec_c;
    logic            err_c;

    // Gather the single-flag set strobes and decode the current CPU
    always_comb begin
        fx_set          = '0;
        fx_set[FX_CRD]  = crd_set;
        fx_set[FX_CDAT] = cdat_set;
        fx_set[FX_FLP]  = flp_set;
        fx_set[FX_RX]   = rx_set;
        cpu_mask        = NCPU'(1) << cpu_id;
        cpu_is0         = (cpu_id == '0);
    end

    irq_flag_bank #(.NCPU(NCPU), .SLOTS(SLOTS), .HW_LEVELS(HW_LEVELS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .fx_set  (fx_set),
        .fx_clr  (fx_clr),
        .clk_set (clk_set),
        .clk_clr (clk_clr),
        .ipi_set (ipi_set),
        .ipi_clr (ipi_clr),
        .tx_set  (tx_set),
        .tx_clr  (tx_clr),
        .hw_set  (hw_set),
        .hw_clr  (hw_clr),
        .fx_q    (fx_q),
        .clk_q   (clk_q),
        .ipi_q   (ipi_q),
        .tx_q    (tx_q),
        .hw_q    (hw_q)
    );

    irq_prio_sel #(.NCPU(NCPU), .SLOTS(SLOTS), .HW_LEVELS(HW_LEVELS)) u_prio (
        .halt_pin (halt_pin),
        .fx_q     (fx_q),
        .clk_q    (clk_q),
        .ipi_q    (ipi_q),
        .tx_q     (tx_q),
        .hw_q     (hw_q),
        .sw_req   (sw_req),
        .cpu_mask (cpu_mask),
        .cpu_is0  (cpu_is0),
        .cur_ipl  (cur_ipl),
        .irq_lvl  (irq_lvl)
    );

    irq_vec_sel #(.NCPU(NCPU), .SLOTS(SLOTS), .HW_LEVELS(HW_LEVELS),
                  .VEC_W(VEC_W), .ADP_SLOT(ADP_SLOT)) u_vec (
        .ack      (ack),
        .ack_lvl  (ack_lvl),
        .fx_q     (fx_q),
        .clk_q    (clk_q),
        .ipi_q    (ipi_q),
        .tx_q     (tx_q),
        .hw_q     (hw_q),
        .cpu_mask (cpu_mask),
        .cpu_is0  (cpu_is0),
        .adp_vec  (adp_vec),
        .vec      (vec_c),
        .err      (err_c),
        .fx_clr   (fx_clr),
        .clk_clr  (clk_clr),
        .ipi_clr  (ipi_clr),
        .tx_clr   (tx_clr),
        .hw_clr   (hw_clr)
    );

    // Register the acknowledge result for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
            ack_err   <= 1'b0;
        end else begin
            vec_valid <= ack;
            ack_err   <= ack & err_c;
            if (ack) vec_out <= vec_c;
        end
    end

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pin |-> (irq_lvl == LVL_HALT));  // R1

    AST_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_pin && (irq_lvl != LVL_NONE)) |-> (irq_lvl > cur_ipl));  // R2

    AST_SW_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_pin && (cur_ipl >= LVL_SW_MAX)) |-> ((irq_lvl == LVL_NONE) || (irq_lvl > cur_ipl)));  // R3

    AST_ACK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);  // R7

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);  // R7

    AST_ERR_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> (vec_valid && (vec_out == '0)));  // R9

endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        halt_pin, crd_set, cdat_set, flp_set, rx_set, ack;
    logic [1:0]  clk_set, ipi_set, tx_set;
    logic [63:0] hw_set;
    logic [14:0] sw_req;
    logic [0:0]  cpu_id;
    logic [4:0]  cur_ipl, ack_lvl, irq_lvl;
    logic [15:0] adp_vec, vec_out;
    logic        vec_valid, ack_err;

    int checks = 0;
    int errors = 0;

    // Bench model of the held flags
    logic        m_crd, m_cdat, m_flp, m_rx;
    logic [1:0]  m_clk, m_ipi, m_tx;
    logic [15:0] m_hw [4];

    always #2.5 clk = ~clk;

    irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .halt_pin(halt_pin), .crd_set(crd_set),
        .clk_set(clk_set), .hw_set(hw_set), .cdat_set(cdat_set),
        .ipi_set(ipi_set), .flp_set(flp_set), .rx_set(rx_set), .tx_set(tx_set),
        .sw_req(sw_req), .cpu_id(cpu_id), .cur_ipl(cur_ipl), .adp_vec(adp_vec),
        .ack(ack), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl), .vec_out(vec_out),
        .vec_valid(vec_valid), .ack_err(ack_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_crd = 0; m_cdat = 0; m_flp = 0; m_rx = 0;
        m_clk = 0; m_ipi = 0; m_tx = 0;
        for (int l = 0; l < 4; l++) m_hw[l] = 0;
    endtask

    task automatic clear_sets();
        halt_pin = 0; crd_set = 0; cdat_set = 0; flp_set = 0; rx_set = 0;
        clk_set = 0; ipi_set = 0; tx_set = 0; hw_set = 0; ack = 0; ack_lvl = 0;
    endtask

    // Expected winning level per R1, R2 and R3
    function automatic logic [4:0] exp_level();
        int c = int'(cpu_id);
        if (halt_pin) return 5'h1F;
        if (m_crd && cur_ipl < 5'h1A) return 5'h1A;
        if (m_clk[c] && cur_ipl < 5'h18) return 5'h18;
        for (int l = 3; l >= 0; l--) begin
            if (5'(20 + l) <= cur_ipl) return 5'h00;
            if (m_hw[l] != 0) return 5'(20 + l);
        end
        if (m_cdat && cur_ipl < 5'h13) return 5'h13;
        if (m_ipi[c] && cur_ipl < 5'h12) return 5'h12;
        if (m_flp && cur_ipl < 5'h11) return 5'h11;
        if (cur_ipl < 5'h10 && ((m_rx && c == 0) || m_tx[c])) return 5'h10;
        if (cur_ipl >= 5'h0F) return 5'h00;
        for (int k = 15; k >= 1; k--)
            if (k > int'(cur_ipl) && sw_req[k-1]) return 5'(k);
        return 5'h00;
    endfunction

    function automatic string lvl_tag(input logic [4:0] lv);
        if (halt_pin) return "R1";
        if (lv != 0 && lv <= 5'h0F) return "R3";
        return "R2";
    endfunction

    // Expected acknowledge result per R4, R5, R6, R8, R9; applies the clears
    task automatic model_ack(input logic [4:0] lv, output logic [15:0] v,
                             output logic e, output string tag);
        int c = int'(cpu_id);
        v = 0; e = 0; tag = "R6";
        if (lv == 5'h1A) begin
            if (m_crd) begin m_crd = 0; v = 16'h054; end
        end else if (lv == 5'h18) begin
            if (m_clk[c]) begin m_clk[c] = 0; v = 16'h0C0; end
        end else if (lv > 5'h17) begin
            e = 1; tag = "R9";
        end else if (lv >= 5'h14) begin
            int l = int'(lv) - 20;
            if (m_hw[l][3]) begin
                m_hw[l][3] = 0; v = adp_vec; tag = "R4";
            end else begin
                bit got = 0;
                tag = "R5";
                for (int s = 0; s < 16; s++) begin
                    if (!got && m_hw[l][s]) begin
                        got = 1; m_hw[l][s] = 0;
                        v = 16'(256 + l * 64 + s * 4);
                    end
                end
            end
        end else if (lv == 5'h13) begin
            if (m_cdat) begin m_cdat = 0; v = 16'h0C8; end
        end else if (lv == 5'h12) begin
            if (m_ipi[c]) begin m_ipi[c] = 0; v = 16'h0CC; end
        end else if (lv == 5'h11) begin
            if (m_flp) begin m_flp = 0; v = 16'h0D0; end
        end else if (lv == 5'h10) begin
            if (m_rx && c == 0) begin m_rx = 0; v = 16'h0F8; end
            else if (m_tx[c]) begin m_tx[c] = 0; v = 16'h0FC; end
        end else if (lv != 0) begin
            v = 16'(128 + 4 * int'(lv)); tag = "R8";
        end
    endtask

    // One clock: check level before the edge, then update model and check result
    task automatic cycle();
        logic [4:0]  el;
        logic [15:0] ev;
        logic        ee, a;
        string       tg;
        #1;
        el = exp_level();
        chk(irq_lvl == el, lvl_tag(el), "irq_lvl", irq_lvl, el);
        a = ack;
        @(posedge clk);
        ev = 0; ee = 0; tg = "R6";
        if (a) model_ack(ack_lvl, ev, ee, tg);
        m_crd |= crd_set; m_cdat |= cdat_set; m_flp |= flp_set; m_rx |= rx_set;
        m_clk |= clk_set; m_ipi |= ipi_set; m_tx |= tx_set;
        for (int l = 0; l < 4; l++) m_hw[l] |= hw_set[l*16 +: 16];
        #1;
        chk(vec_valid == a, "R7", "vec_valid", vec_valid, a);
        if (a) begin
            chk(vec_out == ev, tg, "vec_out", vec_out, ev);
            chk(ack_err == ee, "R9", "ack_err", ack_err, ee);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_sets();
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        sw_req = 0; cpu_id = 0; cur_ipl = 0; adp_vec = 0;
        @(negedge clk);
        do_reset();

        // R11: reset state
        #1;
        chk(irq_lvl == 0, "R11", "irq_lvl after reset", irq_lvl, 0);
        chk(vec_valid == 0 && vec_out == 0 && ack_err == 0, "R11", "outputs after reset",
            {vec_valid, ack_err, vec_out}, 0);
        cycle();

        // R4/R5: level 0x15 with slots 2, 3, 7
        hw_set[16 + 2] = 1; hw_set[16 + 3] = 1; hw_set[16 + 7] = 1;
        cycle(); clear_sets();
        adp_vec = 16'h1234; ack = 1; ack_lvl = 5'h15;
        cycle();
        chk(vec_out == 16'h1234, "R4", "adapter slot vector", vec_out, 16'h1234);
        cycle();
        chk(vec_out == 16'h0148, "R5", "lowest slot vector", vec_out, 16'h0148);
        clear_sets();

        // R1: halt above any level
        halt_pin = 1; cur_ipl = 5'h1F; #1;
        chk(irq_lvl == 5'h1F, "R1", "halt at top ipl", irq_lvl, 5'h1F);
        cycle(); clear_sets(); cur_ipl = 0;

        // R9: acknowledge an unserved high level
        ack = 1; ack_lvl = 5'h1C;
        cycle();
        chk(ack_err == 1 && vec_out == 0, "R9", "error ack", {ack_err, vec_out}, 17'h10000);
        clear_sets();

        // drain slot 7, then R10: floppy set on the same edge as its ack
        ack = 1; ack_lvl = 5'h15; cycle(); clear_sets();
        flp_set = 1; cycle();
        flp_set = 1; ack = 1; ack_lvl = 5'h11; cycle(); clear_sets();
        #1;
        chk(irq_lvl == 5'h11, "R10", "floppy kept after same-edge set", irq_lvl, 5'h11);
        cycle();

        // R11 again after activity
        do_reset();
        #1;
        chk(irq_lvl == 0, "R11", "irq_lvl after second reset", irq_lvl, 0);

        // R3: software levels
        sw_req = 15'h4001; cur_ipl = 3; #1;
        chk(irq_lvl == 5'h0F, "R3", "highest software bit", irq_lvl, 5'h0F);
        cur_ipl = 5'h0F; #1;
        chk(irq_lvl == 0, "R3", "software ceiling", irq_lvl, 0);
        cur_ipl = 0; ack = 1; ack_lvl = 5'h0F; cycle();
        chk(vec_out == 16'h0BC, "R8", "software vector", vec_out, 16'h0BC);
        clear_sets(); sw_req = 0;

        // R6: console receive only for CPU 0, transmit per CPU
        rx_set = 1; tx_set = 2'b10; cpu_id = 1; cycle(); clear_sets();
        ack = 1; ack_lvl = 5'h10; cycle(); clear_sets();
        chk(vec_out == 16'h0FC, "R6", "transmit vector for cpu1", vec_out, 16'h0FC);
        #1;
        chk(irq_lvl == 0, "R6", "receive hidden from cpu1", irq_lvl, 0);
        cpu_id = 0; #1;
        chk(irq_lvl == 5'h10, "R6", "receive seen by cpu0", irq_lvl, 5'h10);
        cycle();

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            clear_sets();
            halt_pin = ($urandom % 40) == 0;
            crd_set  = ($urandom % 20) == 0;
            cdat_set = ($urandom % 12) == 0;
            flp_set  = ($urandom % 12) == 0;
            rx_set   = ($urandom % 12) == 0;
            clk_set  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            ipi_set  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            tx_set   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            for (int l = 0; l < 4; l++)
                if (($urandom % 6) == 0) hw_set[l*16 + ($urandom % 16)] = 1;
            if (($urandom % 10) == 0) sw_req = 15'($urandom) & 15'($urandom);
            r = $urandom % 4;
            cur_ipl = (r == 0) ? 5'd0 : (r == 1) ? 5'($urandom) :
                      (r == 2) ? 5'(16 + $urandom % 8) : 5'($urandom % 16);
            cpu_id  = 1'($urandom);
            adp_vec = 16'($urandom);
            ack     = ($urandom % 3) != 0;
            ack_lvl = (($urandom % 5) == 0) ? 5'($urandom) : exp_level();
            cycle();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule